// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a supervision timer for a small controller. A free-running counter advances on one of two clock enables (a fast system tick or a slow auxiliary tick). When the count crosses a selected power-of-two boundary, the block does one of two things. In watchdog mode it issues a one-cycle reset request. In interval mode it raises a sticky interrupt flag. Software must write the control word before that boundary to clear the counter, or it must stop the counter with a hold bit.

The control word is 16 bits wide. Every write must carry a fixed key in the upper byte. A write with any other upper byte changes nothing and instead triggers a reset request. Reads return a different fixed constant in the upper byte, so software cannot pass on a read value as a valid key by accident.

The lower byte holds the settings:

| Bit | Meaning |
|-----|---------|
| 7 | counter hold |
| 6 | falling-edge select for the external NMI pin |
| 5 | NMI-pin enable |
| 4 | interval mode (0 selects watchdog mode) |
| 3 | counter clear, self-clearing |
| 2 | clock choice |
| 1:0 | interval select |

Bits 6 and 5 are only passed on to the pin logic, which sits outside this block. A write of 0x5A1D selects interval mode, clears the counter and picks the auxiliary tick with an interval of 8192 ticks. With a 32768 Hz auxiliary tick this gives 250 ms.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After reset, bus_rdata reads 0x6900, and rst_req, irq_flag and nmi_cfg are all 0. The block is in watchdog mode with the fast tick and the longest interval.
- R2: The upper byte of bus_rdata is always 0x69. Lower bit 3 always reads 0. The other lower bits show the stored settings.
- R3: A bus_wr whose bus_wdata[15:8] equals 0x5A stores bus_wdata[7:0] as the settings, and bus_rdata shows them from the next cycle. The fields are: bit 7 hold, bit 6 NMI falling edge, bit 5 NMI enable, bit 4 interval mode, bit 3 clear, bit 2 clock choice, bits 1:0 interval select.
- R4: A bus_wr with any other upper byte leaves the settings unchanged and drives rst_req high for exactly the one cycle after the write.
- R5: While bit 7 is 1 the counter does not advance. No expiry occurs, and the count is kept for when the hold is released.
- R6: Interval select codes 00, 01, 10 and 11 give expiry after 32768, 8192, 512 and 64 ticks of the selected enable after the counter was cleared.
- R7: Bit 2 = 0 counts fast_tick and bit 2 = 1 counts aux_tick. The enable that is not selected has no effect.
- R8: In watchdog mode (bit 4 = 0) an expiry drives rst_req high for one cycle and leaves irq_flag unchanged.
- R9: In interval mode an expiry sets irq_flag and does not assert rst_req. irq_flag stays set until irq_clr is high. A new expiry in the same cycle as irq_clr leaves the flag set.
- R10: A keyed write with bit 3 = 1 zeroes the counter at that edge, and the clear wins over an increment in the same cycle. A full interval then passes before the next expiry.
- R11: nmi_cfg[1] equals stored bit 6 and nmi_cfg[0] equals stored bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | Fast count enable |
| aux_tick | input | 1 | Auxiliary (slow) count enable |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 16 | Write data, key in the upper byte |
| bus_rdata | output | 16 | Read data: read constant plus settings |
| irq_clr | input | 1 | Clears irq_flag when high |
| rst_req | output | 1 | One-cycle reset request |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| nmi_cfg | output | 2 | NMI pin configuration {falling edge, enable} |

## Verification
Two events can fall in the same clock edge: an interval expiry that sets the interrupt flag, and the software strobe that clears it. The bench provokes this by doing a clearing write in interval mode with the 64-tick interval, counting exactly 63 ticks, and then raising irq_clr for the edge that carries the 64th tick. The flag must read 1 after that edge, because the new event must not be lost. The same exact count also shows that a clearing write beats the increment that happens at its own edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Settings byte. The bit order matters: software writes whole bytes.
   typedef struct packed {
      logic       hold;      // bit 7
      logic       nmi_fall;  // bit 6
      logic       nmi_pin;   // bit 5
      logic       iv_mode;   // bit 4
      logic       cnt_clr;   // bit 3, never stored as 1
      logic       clk_alt;   // bit 2
      logic [1:0] tap_sel;   // bits 1:0
   } wdog_ctl_t;

   localparam int unsigned CTL_W   = 8;
   localparam int unsigned CLR_BIT = 3;
   localparam int unsigned N_TAPS  = 4;

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
   import wdog_pkg::*;
#(
   parameter int unsigned          KEY_W  = 8,
   parameter logic [KEY_W-1:0]     KEY_WR = 8'h5A,
   localparam int unsigned         BUS_W  = KEY_W + CTL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wdata,
   output wdog_ctl_t        ctl,
   output logic             clr_pulse,
   output logic             key_fault
);

   wdog_ctl_t ctl_q;
   logic      key_ok;

   assign key_ok    = (wdata[BUS_W-1 -: KEY_W] == KEY_WR);
   assign key_fault = wr_en && !key_ok;
   assign clr_pulse = wr_en && key_ok && wdata[CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en && key_ok) begin
         ctl_q         <= wdog_ctl_t'(wdata[CTL_W-1:0]);
         ctl_q.cnt_clr <= 1'b0;
      end
   end

   assign ctl = ctl_q;

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned TAP0  = 15,
   parameter int unsigned TAP1  = 13,
   parameter int unsigned TAP2  = 9,
   parameter int unsigned TAP3  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_fast,
   input  logic       tick_alt,
   input  logic       hold,
   input  logic       clk_alt,
   input  logic [1:0] tap_sel,
   input  logic       clr,
   output logic       expire
);

   localparam int unsigned TAPS [N_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask [N_TAPS];
   logic [CNT_W-1:0] sel_mask;
   logic             tick;
   logic             inc;

   // One mask per interval choice. The low bits below the tap are all ones
   // just before the count carries into the tap bit.
   for (genvar i = 0; i < N_TAPS; i++) begin : g_mask
      assign mask[i] = (CNT_W'(1) << TAPS[i]) - CNT_W'(1);
   end

   assign tick     = clk_alt ? tick_alt : tick_fast;
   assign inc      = tick && !hold;
   assign sel_mask = mask[tap_sel];
   assign expire   = inc && !clr && ((cnt_q & sel_mask) == sel_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/wdog_evt.sv
module wdog_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic iv_mode,
   input  logic key_fault,
   input  logic irq_clr,
   output logic rst_req,
   output logic irq_flag
);

   logic rst_q;
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         rst_q <= key_fault || (expire && !iv_mode);
         // A new event wins over a clear in the same cycle.
         irq_q <= (expire && iv_mode) || (irq_q && !irq_clr);
      end
   end

   assign rst_req  = rst_q;
   assign irq_flag = irq_q;

endmodule

// File: rtl/wdog_keyed_timer.sv
module wdog_keyed_timer
   import wdog_pkg::*;
#(
   parameter int unsigned      CNT_W  = 16,
   parameter int unsigned      KEY_W  = 8,
   parameter logic [KEY_W-1:0] KEY_WR = 8'h5A,
   parameter logic [KEY_W-1:0] KEY_RD = 8'h69,
   parameter int unsigned      TAP0   = 15,
   parameter int unsigned      TAP1   = 13,
   parameter int unsigned      TAP2   = 9,
   parameter int unsigned      TAP3   = 6,
   localparam int unsigned     BUS_W  = KEY_W + CTL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_tick,
   input  logic             aux_tick,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             irq_clr,
   output logic             rst_req,
   output logic             irq_flag,
   output logic [1:0]       nmi_cfg
);

   initial begin
      assert (TAP0 < CNT_W && TAP1 < CNT_W && TAP2 < CNT_W && TAP3 < CNT_W)
         else $error("interval tap outside counter width");
      assert (KEY_WR != KEY_RD)
         else $error("write key must differ from read constant");
   end

   wdog_ctl_t ctl;
   logic      clr_pulse;
   logic      key_fault;
   logic      expire;

   wdog_ctl_reg #(
      .KEY_W  (KEY_W),
      .KEY_WR (KEY_WR)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .wdata     (bus_wdata),
      .ctl       (ctl),
      .clr_pulse (clr_pulse),
      .key_fault (key_fault)
   );

   wdog_cnt #(
      .CNT_W (CNT_W),
      .TAP0  (TAP0),
      .TAP1  (TAP1),
      .TAP2  (TAP2),
      .TAP3  (TAP3)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_fast (fast_tick),
      .tick_alt  (aux_tick),
      .hold      (ctl.hold),
      .clk_alt   (ctl.clk_alt),
      .tap_sel   (ctl.tap_sel),
      .clr       (clr_pulse),
      .expire    (expire)
   );

   wdog_evt u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .iv_mode   (ctl.iv_mode),
      .key_fault (key_fault),
      .irq_clr   (irq_clr),
      .rst_req   (rst_req),
      .irq_flag  (irq_flag)
   );

   assign bus_rdata = {KEY_RD, ctl};
   assign nmi_cfg   = {ctl.nmi_fall, ctl.nmi_pin};

endmodule

// File: rtl/wdog_keyed_timer_chk.sv
module wdog_keyed_timer_chk #(
   parameter int unsigned      KEY_W  = 8,
   parameter logic [KEY_W-1:0] KEY_WR = 8'h5A,
   parameter logic [KEY_W-1:0] KEY_RD = 8'h69,
   localparam int unsigned     BW     = KEY_W + 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [BW-1:0] bus_wdata,
   input logic [BW-1:0] bus_rdata,
   input logic          irq_clr,
   input logic          rst_req,
   input logic          irq_flag,
   input logic [1:0]    nmi_cfg
);

   logic bad_wr;
   logic good_wr;

   assign bad_wr  = bus_wr && (bus_wdata[BW-1 -: KEY_W] != KEY_WR);
   assign good_wr = bus_wr && (bus_wdata[BW-1 -: KEY_W] == KEY_WR);

   p_rdkey_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BW-1 -: KEY_W] == KEY_RD && !bus_rdata[3]);

   p_goodwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> bus_rdata[7:0] == ($past(bus_wdata[7:0]) & 8'hF7));

   p_badkey_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> rst_req);

   p_badkey_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> $stable(bus_rdata));

   p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[7] && !bus_wr |=> !rst_req && !$rose(irq_flag));

   p_ivmode_norst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[4] && !bus_wr |=> !rst_req);

   p_wdmode_noirq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[4] && !irq_flag |=> !irq_flag);

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !irq_clr |=> irq_flag);

   p_nmi_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_cfg == bus_rdata[6:5]);

endmodule

bind wdog_keyed_timer wdog_keyed_timer_chk #(
   .KEY_W  (KEY_W),
   .KEY_WR (KEY_WR),
   .KEY_RD (KEY_RD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_clr   (irq_clr),
   .rst_req   (rst_req),
   .irq_flag  (irq_flag),
   .nmi_cfg   (nmi_cfg)
);

// File: tb/wdog_keyed_timer_bench.sv
module wdog_keyed_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 8;
   // Each entry: {write word, expected read word, expected nmi_cfg, expected reset pulse}
   localparam logic [34:0] VEC [N_VEC] = '{
      {16'h5A80, 16'h6980, 2'b00, 1'b0},
      {16'h5AE8, 16'h69E0, 2'b11, 1'b0},
      {16'h1234, 16'h69E0, 2'b11, 1'b1},
      {16'h5AA4, 16'h69A4, 2'b01, 1'b0},
      {16'h6900, 16'h69A4, 2'b01, 1'b1},
      {16'h5AC1, 16'h69C1, 2'b10, 1'b0},
      {16'hA55A, 16'h69C1, 2'b10, 1'b1},
      {16'h5A9D, 16'h6995, 2'b00, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_tick = 1'b1;
   logic        aux_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_clr = 1'b0;
   logic        rst_req;
   logic        irq_flag;
   logic [1:0]  nmi_cfg;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_keyed_timer u_wdog_keyed_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .aux_tick  (aux_tick),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_clr   (irq_clr),
      .rst_req   (rst_req),
      .irq_flag  (irq_flag),
      .nmi_cfg   (nmi_cfg)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      bus_wr    = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   // Counts falling edges until the chosen output is high; returns -1 past the limit.
   task automatic wait_evt(input bit use_irq, input int limit, output int n);
      n = -1;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if ((use_irq ? irq_flag : rst_req) === 1'b1) begin
            n = k;
            return;
         end
      end
   endtask

   task automatic drop_irq();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", bus_rdata, 16'h6900);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 irq_flag", irq_flag, 0);
      chk("R1 nmi_cfg", nmi_cfg, 0);
      rst_n = 1'b1;

      // R6/R8 default watchdog: longest interval on the fast tick
      wait_evt(1'b0, 40000, n);
      chk("R6 R8 default expiry ticks", n, 32768);
      chk("R8 irq untouched", irq_flag, 0);
      @(negedge clk);
      chk("R8 one-cycle pulse", rst_req, 0);

      // R2/R3/R4/R11 table of writes
      for (int i = 0; i < N_VEC; i++) begin
         wr(VEC[i][34:19]);
         chk("R2 R3 R4 readback", bus_rdata, VEC[i][18:3]);
         chk("R11 nmi_cfg", nmi_cfg, VEC[i][2:1]);
         chk("R4 reset pulse", rst_req, VEC[i][0]);
         @(negedge clk);
         chk("R4 pulse ends", rst_req, 0);
      end

      // R5 hold: no expiry while held, count kept
      wr(16'h5A8B);
      wait_evt(1'b0, 200, n);
      chk("R5 no expiry while held", n, -1);
      wr(16'h5A03);
      wait_evt(1'b0, 100, n);
      chk("R5 R6 expiry after release", n, 64);

      // R10 clear restarts the interval
      wr(16'h5A0B);
      repeat (40) @(negedge clk);
      chk("R10 no early expiry", rst_req, 0);
      wr(16'h5A0B);
      wait_evt(1'b0, 100, n);
      chk("R10 full interval after clear", n, 64);

      // R9 interval mode sets a sticky flag, no reset
      wr(16'h5A1B);
      wait_evt(1'b1, 100, n);
      chk("R9 interval expiry", n, 64);
      chk("R9 no reset in interval mode", rst_req, 0);
      repeat (10) @(negedge clk);
      chk("R9 flag sticky", irq_flag, 1);
      drop_irq();
      chk("R9 flag cleared", irq_flag, 0);

      // R9 set wins over clear in the same cycle
      wr(16'h5A1B);
      repeat (63) @(negedge clk);
      chk("R9 not yet", irq_flag, 0);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R9 set beats clear", irq_flag, 1);
      drop_irq();

      // R7 clock choice: auxiliary tick selected
      wr(16'h5A1F);
      wait_evt(1'b1, 100, n);
      chk("R7 fast tick ignored", n, -1);
      fast_tick = 1'b0;
      aux_tick  = 1'b1;
      wr(16'h5A1F);
      wait_evt(1'b1, 100, n);
      chk("R7 aux tick counted", n, 64);
      fast_tick = 1'b1;
      aux_tick  = 1'b0;
      drop_irq();

      // R6 remaining intervals
      wr(16'h5A1A);
      wait_evt(1'b1, 1000, n);
      chk("R6 code 10 interval", n, 512);
      drop_irq();
      wr(16'h5A19);
      wait_evt(1'b1, 9000, n);
      chk("R6 code 01 interval", n, 8192);
      drop_irq();

      summary();
      $finish;
   end

endmodule